// File: doc/BRIEF.md
# Shift-and-Add Result Combiner

This block is the output stage that follows a bank of multiply-accumulate cells. It receives the current value of every cell accumulator (eight 26-bit words by default) and a cell address. It works in one of two ways. It can pass the addressed accumulator straight to its result port. It can also combine partial products from a wider-operand computation: each cycle it adds the addressed accumulator to its own running buffer, arithmetically shifted right by 8 bits, and writes the sum back into the buffer.

A single mode bit drives both functions. It chooses the second adder operand (zero or the shifted buffer), and its two-cycle history chooses what the result port shows. While the address stays the same, the result port holds the value captured when that address was first seen. A slow consumer can therefore read one value over several cycles. Each half of the result has an active-low enable. A disabled half reads as zero and its valid flag drops.

Top module: `sa_combiner`

## Requirements
- R1: The address input `sel` passes through one register before it selects an accumulator. The value applied before clock edge k addresses the accumulator during the cycle that follows edge k.
- R2: When the registered mode bit is 1, the buffer is loaded with (selected accumulator + buffer arithmetically shifted right by 8, sign-extended to 26 bits), modulo 2^26.
- R3: When the registered mode bit is 0, the adder's second operand is zero, so the buffer is loaded with the selected accumulator.
- R4: When the registered mode bit was 0 in the current cycle and in the previous cycle, and the registered address differs from its previous value, the output register loads the selected accumulator. It appears on `result` after the next edge.
- R5: When the output shows accumulators and the registered address equals its value from the previous cycle, the output keeps the value captured on the first cycle of that selection. Later changes to that accumulator are ignored.
- R6: In every other case (the registered mode bit was 1 in the current or the previous cycle), the output register loads the new buffer value.
- R7: When `hi_en_n` is 1, `result[25:16]` reads 0 and `hi_valid` is 0. Otherwise they carry the output register and `hi_valid` is 1.
- R8: When `lo_en_n` is 1, `result[15:0]` reads 0 and `lo_valid` is 0. Otherwise they carry the output register and `lo_valid` is 1.
- R9: A synchronous active-high reset clears the buffer, the output register, the hold register and the address and mode history. The first address seen after reset counts as a new selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_flat | input | 208 | Accumulator values, cell i in bits [26*i+25 : 26*i] |
| sel | input | 3 | Cell address |
| shadd_mode | input | 1 | 1 = shift-and-add into buffer; 0 = zero operand / accumulator output |
| hi_en_n | input | 1 | Active-low enable for result bits 25..16 |
| lo_en_n | input | 1 | Active-low enable for result bits 15..0 |
| result | output | 26 | Combined or forwarded result |
| hi_valid | output | 1 | Upper half of result is enabled |
| lo_valid | output | 1 | Lower half of result is enabled |

## Verification
The bench drives negative accumulators through repeated shift-and-add passes. A logical shift in place of an arithmetic one would leave large positive buffers where the reference expects negative ones. It holds one address steady while the addressed accumulator keeps changing. A design without the freeze would follow the new values, and a design that freezes on the wrong cycle would show a stale word. It also flips the mode bit for a single cycle, which exercises the two-cycle history: a design that looks only at the current mode would show an accumulator one cycle too early. Finally, it checks the enable halves separately and applies a reset in the middle of a run, after which the buffer must restart from zero.

// File: rtl/sa_comb_pkg.sv
package sa_comb_pkg;

  typedef enum logic {
    SRC_ADDER = 1'b0,
    SRC_HOLD  = 1'b1
  } out_src_e;

  typedef struct packed {
    logic pick_acc;
    logic new_sel;
  } sa_ctrl_t;

endpackage

// File: rtl/sa_ctrl_pipe.sv
module sa_ctrl_pipe #(
  parameter int SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 mode_i,
  output logic [SEL_W-1:0]     sel_q_o,
  output logic                 mode_q_o,
  output sa_comb_pkg::sa_ctrl_t ctrl_o
);

  logic [SEL_W-1:0] sel_q, sel_qq;
  logic             mode_q, mode_qq;
  logic             seen_q;

  // Address and mode history: one stage to use, one stage to compare.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      sel_qq  <= '0;
      mode_q  <= 1'b0;
      mode_qq <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      sel_q   <= sel_i;
      sel_qq  <= sel_q;
      mode_q  <= mode_i;
      mode_qq <= mode_q;
      seen_q  <= 1'b1;
    end
  end

  always_comb begin
    ctrl_o.pick_acc = ~mode_q & ~mode_qq;
    ctrl_o.new_sel  = ~seen_q | (sel_q != sel_qq);
  end

  assign sel_q_o  = sel_q;
  assign mode_q_o = mode_q;

endmodule

// File: rtl/sa_src_mux.sv
module sa_src_mux #(
  parameter int NUM_SRC = 8,
  parameter int ACC_W   = 26,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_SRC*ACC_W-1:0] acc_flat_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [ACC_W-1:0]         acc_sel_o
);

  logic [ACC_W-1:0] taps [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_tap
    assign taps[g] = acc_flat_i[g*ACC_W +: ACC_W];
  end

  always_comb begin
    acc_sel_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_i == SEL_W'(i)) acc_sel_o = taps[i];
    end
  end

endmodule

// File: rtl/sa_shift_acc.sv
module sa_shift_acc #(
  parameter int ACC_W = 26,
  parameter int SHIFT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] addend_i,
  input  logic             use_buf_i,
  output logic [ACC_W-1:0] sum_o,
  output logic [ACC_W-1:0] buf_o
);

  localparam int KEEP_W = ACC_W - SHIFT;

  logic [ACC_W-1:0] buf_q;
  logic [ACC_W-1:0] operand;

  // Arithmetic right shift: keep the upper KEEP_W bits, replicate the sign.
  always_comb begin
    if (use_buf_i) operand = {{SHIFT{buf_q[ACC_W-1]}}, buf_q[ACC_W-1 -: KEEP_W]};
    else           operand = '0;
    sum_o = addend_i + operand;
  end

  always_ff @(posedge clk) begin
    if (rst) buf_q <= '0;
    else     buf_q <= sum_o;
  end

  assign buf_o = buf_q;

endmodule

// File: rtl/sa_out_stage.sv
module sa_out_stage #(
  parameter int ACC_W = 26,
  parameter int HI_W  = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  sa_comb_pkg::sa_ctrl_t ctrl_i,
  input  logic [ACC_W-1:0]      acc_sel_i,
  input  logic [ACC_W-1:0]      sum_i,
  input  logic                  hi_en_n_i,
  input  logic                  lo_en_n_i,
  output logic [ACC_W-1:0]      hold_o,
  output logic [ACC_W-1:0]      out_o,
  output logic [ACC_W-1:0]      result_o,
  output logic                  hi_valid_o,
  output logic                  lo_valid_o
);

  import sa_comb_pkg::*;

  localparam int LO_W = ACC_W - HI_W;

  logic [ACC_W-1:0] hold_q, out_q, capture;
  out_src_e         src;

  always_comb begin
    capture = ctrl_i.new_sel ? acc_sel_i : hold_q;
    src     = ctrl_i.pick_acc ? SRC_HOLD : SRC_ADDER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      hold_q <= capture;
      out_q  <= (src == SRC_HOLD) ? capture : sum_i;
    end
  end

  always_comb begin
    result_o[ACC_W-1 -: HI_W] = hi_en_n_i ? '0 : out_q[ACC_W-1 -: HI_W];
    result_o[LO_W-1:0]        = lo_en_n_i ? '0 : out_q[LO_W-1:0];
    hi_valid_o = ~hi_en_n_i;
    lo_valid_o = ~lo_en_n_i;
  end

  assign hold_o = hold_q;
  assign out_o  = out_q;

endmodule

// File: rtl/sa_combiner.sv
module sa_combiner #(
  parameter int NUM_SRC = 8,
  parameter int ACC_W   = 26,
  parameter int SHIFT   = 8,
  parameter int HI_W    = 10,
  parameter int SEL_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC*ACC_W-1:0] acc_flat,
  input  logic [SEL_W-1:0]         sel,
  input  logic                     shadd_mode,
  input  logic                     hi_en_n,
  input  logic                     lo_en_n,
  output logic [ACC_W-1:0]         result,
  output logic                     hi_valid,
  output logic                     lo_valid
);

  sa_comb_pkg::sa_ctrl_t ctrl;
  logic [SEL_W-1:0] sel_q;
  logic             mode_q;
  logic [ACC_W-1:0] acc_sel, sum, buf_q, hold_q, out_q;
  logic             pick_acc, new_sel;

  sa_ctrl_pipe #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .sel_i(sel), .mode_i(shadd_mode),
    .sel_q_o(sel_q), .mode_q_o(mode_q), .ctrl_o(ctrl)
  );

  sa_src_mux #(.NUM_SRC(NUM_SRC), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_mux (
    .acc_flat_i(acc_flat), .sel_i(sel_q), .acc_sel_o(acc_sel)
  );

  sa_shift_acc #(.ACC_W(ACC_W), .SHIFT(SHIFT)) u_acc (
    .clk(clk), .rst(rst), .addend_i(acc_sel), .use_buf_i(mode_q),
    .sum_o(sum), .buf_o(buf_q)
  );

  sa_out_stage #(.ACC_W(ACC_W), .HI_W(HI_W)) u_out (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .acc_sel_i(acc_sel), .sum_i(sum),
    .hi_en_n_i(hi_en_n), .lo_en_n_i(lo_en_n),
    .hold_o(hold_q), .out_o(out_q),
    .result_o(result), .hi_valid_o(hi_valid), .lo_valid_o(lo_valid)
  );

  assign pick_acc = ctrl.pick_acc;
  assign new_sel  = ctrl.new_sel;

endmodule

// File: rtl/sa_combiner_chk.sv
module sa_combiner_chk #(
  parameter int NUM_SRC = 8,
  parameter int ACC_W   = 26,
  parameter int SHIFT   = 8,
  parameter int HI_W    = 10,
  parameter int SEL_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_SRC*ACC_W-1:0] acc_flat,
  input logic [SEL_W-1:0]         sel_q,
  input logic                     mode_q,
  input logic                     pick_acc,
  input logic                     new_sel,
  input logic [ACC_W-1:0]         buf_q,
  input logic [ACC_W-1:0]         hold_q,
  input logic [ACC_W-1:0]         out_q,
  input logic                     hi_en_n,
  input logic                     lo_en_n,
  input logic [ACC_W-1:0]         result,
  input logic                     hi_valid,
  input logic                     lo_valid
);

  localparam int LO_W = ACC_W - HI_W;

  logic [ACC_W-1:0] picked_chk, shifted_chk;
  assign picked_chk  = acc_flat[int'(sel_q)*ACC_W +: ACC_W];
  assign shifted_chk = ACC_W'($signed(buf_q) >>> SHIFT);

  // R2
  shadd_update_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q |=> buf_q == $past(picked_chk + shifted_chk));

  // R3
  zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_q |=> buf_q == $past(picked_chk));

  // R4
  acc_forward_chk: assert property (@(posedge clk) disable iff (rst)
    (pick_acc && new_sel) |=> out_q == $past(picked_chk));

  // R5
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pick_acc && !new_sel) |=> out_q == $past(hold_q));

  // R6
  buffer_view_chk: assert property (@(posedge clk) disable iff (rst)
    !pick_acc |=> out_q == buf_q);

  // R7
  hi_gate_chk: assert property (@(posedge clk) disable iff (rst)
    hi_en_n |-> (result[ACC_W-1 -: HI_W] == '0) && !hi_valid);

  // R8
  lo_gate_chk: assert property (@(posedge clk) disable iff (rst)
    lo_en_n |-> (result[LO_W-1:0] == '0) && !lo_valid);

endmodule

bind sa_combiner sa_combiner_chk #(
  .NUM_SRC(NUM_SRC), .ACC_W(ACC_W), .SHIFT(SHIFT), .HI_W(HI_W), .SEL_W(SEL_W)
) u_sa_chk (
  .clk(clk), .rst(rst), .acc_flat(acc_flat), .sel_q(sel_q), .mode_q(mode_q),
  .pick_acc(pick_acc), .new_sel(new_sel), .buf_q(buf_q), .hold_q(hold_q),
  .out_q(out_q), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .result(result),
  .hi_valid(hi_valid), .lo_valid(lo_valid)
);

// File: tb/sa_combiner_bench.sv
`timescale 1ns/1ps
module sa_combiner_bench;

  localparam int N  = 8;
  localparam int W  = 26;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] acc_v [N];
  logic [N*W-1:0] acc_flat;
  logic [2:0] sel = '0;
  logic shadd_mode = 1'b0, hi_en_n = 1'b0, lo_en_n = 1'b0;
  logic [W-1:0] result;
  logic hi_valid, lo_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) acc_flat[i*W +: W] = acc_v[i];

  sa_combiner u_sa_combiner (
    .clk(clk), .rst(rst), .acc_flat(acc_flat), .sel(sel),
    .shadd_mode(shadd_mode), .hi_en_n(hi_en_n), .lo_en_n(lo_en_n),
    .result(result), .hi_valid(hi_valid), .lo_valid(lo_valid)
  );

  // Behavioural reference state
  int unsigned m_sq = 0, m_sqq = 0;
  bit m_mq = 0, m_mqq = 0, m_seen = 0;
  logic [W-1:0] m_hold = '0, m_buf = '0, m_out = '0;
  string m_tag = "R9";

  task automatic model_step(input bit r);
    logic [W-1:0] a, cap, sx, sm;
    logic signed [W-1:0] bs;
    bit fresh, pick;
    if (r) begin
      m_sq = 0; m_sqq = 0; m_mq = 0; m_mqq = 0; m_seen = 0;
      m_hold = '0; m_buf = '0; m_out = '0; m_tag = "R9";
      return;
    end
    a = acc_v[m_sq];
    fresh = !m_seen || (m_sq != m_sqq);
    pick  = !m_mq && !m_mqq;
    cap = fresh ? a : m_hold;
    bs = m_buf;
    sx = m_mq ? W'(bs >>> 8) : '0;
    sm = a + sx;
    m_out = pick ? cap : sm;
    if (pick) m_tag = fresh ? "R4 R1" : "R5";
    else      m_tag = m_mq ? "R2 R6" : "R3 R6";
    m_hold = cap; m_seen = 1; m_buf = sm;
    m_sqq = m_sq; m_sq = int'(sel);
    m_mqq = m_mq; m_mq = shadd_mode;
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [W-1:0] exp_hi, exp_lo, act_hi, act_lo;
    exp_hi = hi_en_n ? '0 : {m_out[25:16], 16'h0};
    exp_lo = lo_en_n ? '0 : {10'h0, m_out[15:0]};
    act_hi = {result[25:16], 16'h0};
    act_lo = {10'h0, result[15:0]};
    check(hi_en_n ? "R7" : m_tag, act_hi, exp_hi);
    check(lo_en_n ? "R8" : m_tag, act_lo, exp_lo);
    check("R7 valid", W'(hi_valid), W'(!hi_en_n));
    check("R8 valid", W'(lo_valid), W'(!lo_en_n));
  endtask

  // One clock: inputs already set at negedge; model follows the edge.
  task automatic cyc(input logic [2:0] s, input bit m, input bit he, input bit le, input bit r);
    sel = s; shadd_mode = m; hi_en_n = he; lo_en_n = le; rst = r;
    @(posedge clk);
    @(negedge clk);
    model_step(r);
    compare();
  endtask

  initial begin
    for (int i = 0; i < N; i++) acc_v[i] = W'(32'h100 * (i + 1));
    @(negedge clk);
    // R9: reset state
    for (int k = 0; k < 3; k++) cyc(3'd0, 0, 0, 0, 1);
    check("R9 reset result", result, '0);

    // R1 R4: sequential addressing, mode low
    for (int k = 0; k < 20; k++) begin
      for (int i = 0; i < N; i++) acc_v[i] = W'($urandom);
      cyc(3'(k % N), 0, 0, 0, 0);
    end

    // R5: address held while the accumulator keeps changing
    for (int k = 0; k < 6; k++) begin
      acc_v[3] = W'(32'h12345 + k * 32'h1111);
      cyc(3'd3, 0, 0, 0, 0);
    end
    cyc(3'd5, 0, 0, 0, 0);
    cyc(3'd5, 0, 0, 0, 0);

    // R2 R3 R6: shift-and-add with negative partials
    acc_v[0] = 26'h3FF_FF00; acc_v[1] = 26'h380_0000;
    acc_v[2] = 26'h000_1234; acc_v[4] = 26'h2AA_AAAA;
    cyc(3'd0, 0, 0, 0, 0);
    cyc(3'd1, 1, 0, 0, 0);
    cyc(3'd2, 1, 0, 0, 0);
    cyc(3'd4, 1, 0, 0, 0);
    cyc(3'd1, 1, 0, 0, 0);
    // single low cycle: still buffer (R6), then accumulators again (R4)
    cyc(3'd2, 0, 0, 0, 0);
    cyc(3'd0, 1, 0, 0, 0);
    cyc(3'd1, 0, 0, 0, 0);
    cyc(3'd2, 0, 0, 0, 0);
    cyc(3'd3, 0, 0, 0, 0);
    cyc(3'd4, 0, 0, 0, 0);

    // R7 R8: enable combinations
    for (int k = 0; k < 8; k++) begin
      acc_v[k] = W'($urandom);
      cyc(3'(k), 0, k[0], k[1], 0);
    end

    // R9: reset in the middle of a shift-and-add run
    for (int k = 0; k < 4; k++) cyc(3'(k), 1, 0, 0, 0);
    cyc(3'd0, 1, 0, 0, 1);
    check("R9 mid reset result", result, '0);
    cyc(3'd0, 1, 0, 0, 0);
    cyc(3'd0, 1, 0, 0, 0);
    cyc(3'd1, 1, 0, 0, 0);

    // Mixed random traffic with frequent address repeats
    for (int k = 0; k < 400; k++) begin
      logic [2:0] s;
      for (int i = 0; i < N; i++) if ($urandom % 2 == 0) acc_v[i] = W'($urandom);
      s = ($urandom % 3 == 0) ? 3'($urandom) : sel;
      cyc(s, ($urandom % 3 == 0), ($urandom % 6 == 0), ($urandom % 6 == 0), ($urandom % 97 == 0));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(WD_CYCLES * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule